// File: doc/BRIEF.md
# Four-Channel Prescaled Countdown Timer

This block holds four independent down-counters, each reached through a small memory-mapped register window on a simple synchronous read/write port. Software sets a reload value, picks a count rate (every clock, every 16th clock or every 256th clock), and picks single-shot or repeating operation. When an armed counter reaches zero it disarms itself and, if its enable bit is set, raises a level interrupt request on its own line.

The request stays high until software acknowledges it. Writing the channel's load, control or clear register acknowledges it. A clear write also restarts a repeating channel from its reload value. A single-shot channel stays stopped until it is reloaded or re-enabled. The two slower rates come from one free-running prescaler that all four channels share.

Top module: `qtmr_top`

## Requirements
- R1: Address bits [6:5] select the channel and bits [3:2] select the register: 0 = load, 1 = value, 2 = control, 3 = clear. All other address bits are ignored. A read presented in one cycle returns its data on `rdata` after the next rising edge, and `rdata` holds when no read is presented.
- R2: The control register is 4 bits. Bit 0 is enable, bit 1 is periodic, bit 2 is divide-by-16 and bit 3 is divide-by-256. A control read returns these bits in [3:0] with zeros above.
- R3: Writing load stores wdata[23:0] into both the reload register and the counter, arms the channel, and drops its interrupt request.
- R4: Every control write drops the channel's interrupt request. When the written enable bit is 1, the write also copies the reload value into the counter and arms the channel.
- R5: An armed channel decrements once per selected tick. At zero it disarms, and the count never wraps below zero.
- R6: Expiry raises the interrupt request only when the enable bit is 1.
- R7: A value write sets the counter to wdata[23:0] and leaves the armed state unchanged. A value read returns the live count.
- R8: A clear write always drops the interrupt request. In periodic mode it also reloads the counter and rearms the channel; in single-shot mode it does neither. Reading clear returns 0.
- R9: After reset every channel has reload 0xFFFFFF, count 0, control 0x2 (periodic, disabled, undivided), and is disarmed with its interrupt low.
- R10: With divide-by-16, a channel armed with count N raises its request between 16(N-1)+1 and 16N clocks after arming. With divide-by-256 the window is 256(N-1)+1 to 256N clocks.
- R11: An interrupt request stays high until one of the acknowledging writes occurs.
- R12: When both divide bits are set, divide-by-256 is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current cycle |
| rd_en | input | 1 | Read strobe for the current cycle |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 4 | Level interrupt request, one bit per channel |

## Verification
Register writes take effect at the edge that samples them. Read data appears one edge after the read strobe, so the bench samples `rdata` at the falling edge after that. At the undivided rate, a channel armed with N at edge e0 raises its request at edge e0+N. The bench checks the request level at e0+N-1 and again at e0+N.

The prescaler phase is not visible at the ports. For the divided rates the bench therefore checks the two ends of the R10 window: the request is still low at 16(N-1) or 256(N-1) clocks and is high at 16N or 256N. Acknowledges are checked at the falling edge right after the acknowledging write.

// File: rtl/qtmr_pkg.sv
package qtmr_pkg;

  localparam int CTRL_W  = 4;
  localparam int CB_EN   = 0;
  localparam int CB_PER  = 1;
  localparam int CB_D16  = 2;
  localparam int CB_D256 = 3;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 4'b0010;

  typedef enum logic [1:0] {
    REG_LOAD  = 2'd0,
    REG_VALUE = 2'd1,
    REG_CTRL  = 2'd2,
    REG_CLEAR = 2'd3
  } reg_sel_e;

  // Select the count enable for a channel: the slow rate wins over the medium one.
  function automatic logic tick_pick(input logic [CTRL_W-1:0] ctrl,
                                     input logic t16, input logic t256);
    if (ctrl[CB_D256])     return t256;
    else if (ctrl[CB_D16]) return t16;
    else                   return 1'b1;
  endfunction

endpackage

// File: rtl/qtmr_prescale.sv
module qtmr_prescale #(
  parameter int LO_LOG = 4,
  parameter int HI_LOG = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_lo,
  output logic tick_hi
);

  logic [HI_LOG-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_q + 1'b1;
  end

  assign tick_lo = &phase_q[LO_LOG-1:0];
  assign tick_hi = &phase_q;

  AST_TICK_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    tick_hi |-> tick_lo); // R10

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick_lo |=> !tick_lo); // R10

endmodule

// File: rtl/qtmr_channel.sv
module qtmr_channel
  import qtmr_pkg::*;
#(
  parameter int W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_load,
  input  logic              wr_value,
  input  logic              wr_ctrl,
  input  logic              wr_clear,
  input  logic [W-1:0]      wdata,
  input  logic              tick16,
  input  logic              tick256,
  output logic [W-1:0]      load_q,
  output logic [W-1:0]      count_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              irq
);

  logic         armed_q;
  logic         irq_q;
  logic         any_wr;
  logic         ack;
  logic         step;
  logic         expire;
  logic [W-1:0] nxt;

  // Count one step toward zero without wrapping.
  function automatic logic [W-1:0] count_step(input logic [W-1:0] c);
    return (c == '0) ? '0 : c - W'(1);
  endfunction

  assign any_wr = wr_load | wr_value | wr_ctrl | wr_clear;
  assign ack    = wr_load | wr_ctrl | wr_clear;
  assign step   = armed_q & tick_pick(ctrl_q, tick16, tick256);
  assign nxt    = count_step(count_q);
  assign expire = step & ~any_wr & (nxt == '0);
  assign irq    = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= '1;
      count_q <= '0;
      ctrl_q  <= CTRL_RESET;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else if (wr_load) begin
      load_q  <= wdata;
      count_q <= wdata;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_q <= wdata[CTRL_W-1:0];
      irq_q  <= 1'b0;
      if (wdata[CB_EN]) begin
        count_q <= load_q;
        armed_q <= 1'b1;
      end
    end else if (wr_clear) begin
      irq_q <= 1'b0;
      if (ctrl_q[CB_PER]) begin
        count_q <= load_q;
        armed_q <= 1'b1;
      end
    end else if (wr_value) begin
      count_q <= wdata;
    end else if (step) begin
      count_q <= nxt;
      if (expire) begin
        armed_q <= 1'b0;
        if (ctrl_q[CB_EN]) irq_q <= 1'b1;
      end
    end
  end

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq); // R3

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq); // R11

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ctrl_q[CB_EN]); // R6

  AST_EXPIRE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !armed_q); // R5

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !any_wr && count_q != '0) |=> (count_q == ($past(count_q) - W'(1)))); // R5

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !any_wr) |=> $stable(count_q)); // R7

endmodule

// File: rtl/qtmr_top.sv
module qtmr_top
  import qtmr_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    irq
);

  localparam int CH_BITS = $clog2(NCH);
  localparam int CH_LSB  = 5;
  localparam int CH_MSB  = CH_LSB + CH_BITS - 1;

  logic [CH_BITS-1:0] ch_sel;
  reg_sel_e           reg_sel;
  logic               tick16;
  logic               tick256;
  logic               addr_unused;

  logic [CNT_W-1:0]  load_a  [NCH];
  logic [CNT_W-1:0]  count_a [NCH];
  logic [CTRL_W-1:0] ctrl_a  [NCH];

  assign ch_sel  = addr[CH_MSB:CH_LSB];
  assign reg_sel = reg_sel_e'(addr[3:2]);
  assign addr_unused = ^{addr[1:0], addr[4], addr[ADDR_W-1:CH_MSB+1], wdata[DATA_W-1:CNT_W]};

  qtmr_prescale #(.LO_LOG(4), .HI_LOG(8)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_lo (tick16),
    .tick_hi (tick256)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = wr_en && (ch_sel == CH_BITS'(c));

    qtmr_channel #(.W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_load  (hit && reg_sel == REG_LOAD),
      .wr_value (hit && reg_sel == REG_VALUE),
      .wr_ctrl  (hit && reg_sel == REG_CTRL),
      .wr_clear (hit && reg_sel == REG_CLEAR),
      .wdata    (wdata[CNT_W-1:0]),
      .tick16   (tick16),
      .tick256  (tick256),
      .load_q   (load_a[c]),
      .count_q  (count_a[c]),
      .ctrl_q   (ctrl_a[c]),
      .irq      (irq[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      unique case (reg_sel)
        REG_LOAD:  rdata <= DATA_W'(load_a[ch_sel]);
        REG_VALUE: rdata <= DATA_W'(count_a[ch_sel]);
        REG_CTRL:  rdata <= DATA_W'(ctrl_a[ch_sel]);
        default:   rdata <= '0;
      endcase
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R1

endmodule

// File: tb/tb_qtmr_top.sv
`timescale 1ns/1ps
module tb_qtmr_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  qtmr_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  typedef struct packed {
    logic        rd;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
    logic [3:0]  eirq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 8'h00, 32'h0,          32'h00FF_FFFF, 4'h0}, // R9 ch0 reload
    '{1'b1, 8'h08, 32'h0,          32'h0000_0002, 4'h0}, // R9 R2 ch0 control
    '{1'b1, 8'h68, 32'h0,          32'h0000_0002, 4'h0}, // R9 ch3 control
    '{1'b1, 8'h60, 32'h0,          32'h00FF_FFFF, 4'h0}, // R9 ch3 reload
    '{1'b0, 8'h64, 32'h12AB_CDEF,  32'h0,         4'h0}, // R7 value write
    '{1'b1, 8'h64, 32'h0,          32'h00AB_CDEF, 4'h0}, // R7 masked
    '{1'b1, 8'h64, 32'h0,          32'h00AB_CDEF, 4'h0}, // R7 disarmed holds
    '{1'b0, 8'h28, 32'h0,          32'h0,         4'h0}, // R2 ch1 one-shot off
    '{1'b1, 8'h28, 32'h0,          32'h0000_0000, 4'h0}, // R2
    '{1'b0, 8'h20, 32'hFF00_0010,  32'h0,         4'h0}, // R3 load ch1
    '{1'b1, 8'h20, 32'h0,          32'h0000_0010, 4'h0}, // R3 masked
    '{1'b1, 8'h2C, 32'h0,          32'h0000_0000, 4'h0}  // R8 clear reads 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wait_edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    wait_edges(3);
    rst_n = 1'b1;
    wait_edges(1);
    check("R9 irq after reset", {28'h0, irq}, 32'h0);
    check("R9 rdata after reset", rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = ~TBL[i].rd; rd_en = TBL[i].rd; addr = TBL[i].a; wdata = TBL[i].d;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      if (TBL[i].rd) check($sformatf("R1 table %0d rdata", i), rdata, TBL[i].exp);
      check($sformatf("R11 table %0d irq", i), {28'h0, irq}, {28'h0, TBL[i].eirq});
    end

    // R6: ch1 one-shot with enable clear expires silently
    wait_edges(20);
    check("R6 ch1 irq stays low", {31'h0, irq[1]}, 32'h0);
    rd(8'h24, v);
    check("R5 ch1 count clamped at zero", v, 32'h0);

    // R5 one-shot expiry at undivided rate
    wr(8'h08, 32'h1);
    wr(8'h00, 32'h5);
    wait_edges(4);
    check("R5 ch0 not yet expired", {31'h0, irq[0]}, 32'h0);
    wait_edges(1);
    check("R5 ch0 expiry irq", {31'h0, irq[0]}, 32'h1);
    wait_edges(10);
    check("R11 ch0 irq held", {31'h0, irq[0]}, 32'h1);
    rd(8'h13, v);
    check("R1 alias address reads ch0 reload", v, 32'h5);
    wr(8'h0C, 32'h0);
    check("R8 clear acks one-shot", {31'h0, irq[0]}, 32'h0);
    wait_edges(10);
    check("R8 one-shot not rearmed", {31'h0, irq[0]}, 32'h0);
    rd(8'h04, v);
    check("R8 one-shot count stays zero", v, 32'h0);

    // R4 R8 periodic reload on ch2
    wr(8'h40, 32'h3);
    wr(8'h48, 32'h3);
    wait_edges(2);
    check("R4 ch2 not yet expired", {31'h0, irq[2]}, 32'h0);
    wait_edges(1);
    check("R4 ch2 expiry after enable", {31'h0, irq[2]}, 32'h1);
    wr(8'h4C, 32'h0);
    check("R8 clear acks periodic", {31'h0, irq[2]}, 32'h0);
    wait_edges(2);
    check("R8 reloaded not yet expired", {31'h0, irq[2]}, 32'h0);
    wait_edges(1);
    check("R8 periodic rearmed expiry", {31'h0, irq[2]}, 32'h1);

    // R3 load write acks, R4 control write acks without reload
    wr(8'h40, 32'h8);
    check("R3 load write acks", {31'h0, irq[2]}, 32'h0);
    wait_edges(8);
    check("R3 reloaded expiry", {31'h0, irq[2]}, 32'h1);
    wr(8'hC8, 32'h2);
    check("R4 control write acks", {31'h0, irq[2]}, 32'h0);
    rd(8'h44, v);
    check("R4 no reload without enable", v, 32'h0);
    rd(8'h48, v);
    check("R2 control readback", v, 32'h2);

    // R7 value write on an armed channel
    wr(8'h28, 32'h1);
    wr(8'h24, 32'h2);
    wait_edges(1);
    check("R7 not yet expired", {31'h0, irq[1]}, 32'h0);
    wait_edges(1);
    check("R7 value write shortens run", {31'h0, irq[1]}, 32'h1);

    // R10 divide-by-16
    wr(8'h68, 32'h5);
    wr(8'h60, 32'h3);
    wait_edges(32);
    check("R10 div16 early edge", {31'h0, irq[3]}, 32'h0);
    wait_edges(16);
    check("R10 div16 late edge", {31'h0, irq[3]}, 32'h1);

    // R12 both divide bits: slow rate wins
    wr(8'h68, 32'hD);
    check("R4 control ack ch3", {31'h0, irq[3]}, 32'h0);
    wait_edges(512);
    check("R12 both bits early edge", {31'h0, irq[3]}, 32'h0);
    wait_edges(256);
    check("R12 both bits late edge", {31'h0, irq[3]}, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule